// File: doc/BRIEF.md
# Teletext Bit Slot Timer

This block paces serial teletext data arriving at 6.9375 Mbps against a 27 MHz pixel clock. Because the ratio of the two rates is not an integer, it follows a fixed fractional schedule. Each group of 37 bits spans exactly 144 clocks. In every group, bits 10, 19, 28 and 37 are held for three clocks, and every other bit is held for four. The schedule repeats until 360 bits (45 bytes) have been taken for the line.

A line begins with a one-cycle `line_start` pulse. The line framing logic upstream decides which lines carry teletext. From that pulse on, the block samples the selected input pin in the last clock of each bit slot and presents the bit with a one-cycle valid strobe.

It also drives a request output that tells the upstream source when to present data. The request can span the whole line or pulse once per bit. In both cases it leads the sampling by a programmable number of clocks.

Top module: `ttx_slot_timer`

## Requirements
- R1: While `en` is low, `bit_valid` and `ttx_req` stay low from the next cycle on. Lowering `en` mid-line aborts the line, and raising it again does not resume that line.
- R2: Cycle 0 is the first cycle after the clock edge that samples `line_start`. Bit k (1-based position p = ((k-1) mod 37) + 1) lasts 3 clocks when p is 10, 19, 28 or 37, and 4 clocks otherwise, so each 37-bit group takes 144 clocks.
- R3: Exactly 360 strobes are produced per line, and none follow the 360th.
- R4: Each bit is sampled in the last clock of its slot. `bit_valid` is high for one cycle, in the cycle after that last clock, with `bit_data` holding the sampled value.
- R5: `src_sel` = 0 samples `data_in_a`, and `src_sel` = 1 samples `data_in_b`.
- R6: Line mode (`req_bitmode` = 0) uses the lead L taken from `req_lead` at line start and the line length T = 1402 clocks. `ttx_req` is high in cycles 0 through T-1-L of the line and low otherwise.
- R7: In bit mode (`req_bitmode` = 1), for each bit whose last clock is cycle e, `ttx_req` is high in cycles e-L through e-L+W-1, where W = `req_width` + 1.
- R8: A `line_start` pulse arriving while `en` is high and a line is running restarts the line from bit 1 and drops the interrupted bit. A `line_start` pulse arriving while `en` is low is ignored.
- R9: After reset, `bit_valid`, `bit_data` and `ttx_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Insertion enable |
| req_bitmode | input | 1 | 0: line-wide request, 1: per-bit request pulse |
| src_sel | input | 1 | Data pin select: 0 = data_in_a, 1 = data_in_b |
| req_lead | input | 2 | Request lead in clocks, taken at line start |
| req_width | input | 2 | Bit-mode pulse width minus one |
| line_start | input | 1 | One-cycle start-of-line pulse |
| data_in_a | input | 1 | Serial data on the frame-sync pin |
| data_in_b | input | 1 | Serial data on pixel bit 0 |
| ttx_req | output | 1 | Data request to the upstream source |
| bit_data | output | 1 | Sampled teletext bit |
| bit_valid | output | 1 | One-cycle strobe for bit_data |

## Verification
The assertions take for granted three things about the inputs:
- `line_start` is a single-cycle pulse.
- `req_bitmode`, `req_width` and `src_sel` are changed only between lines.
- The data pins settle one full clock before the edge that samples them.

The stimulus follows these rules. It drives every input on the falling clock edge, and it changes the configuration only in the cycle that raises `line_start`. It sweeps every lead and width value in both request modes and on both source pins. Restart and disable events are placed mid-line, away from a line end.

// File: rtl/ttx_slot_timer.sv
module ttx_slot_timer #(
  parameter int LINE_BITS  = 360,
  parameter int GROUP_BITS = 37,
  parameter int SHORT_STEP = 9,
  parameter int LONG_HOLD  = 4,
  parameter int LEAD_W     = 2,
  parameter int WIDTH_W    = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               req_bitmode,
  input  logic               src_sel,
  input  logic [LEAD_W-1:0]  req_lead,
  input  logic [WIDTH_W-1:0] req_width,
  input  logic               line_start,
  input  logic               data_in_a,
  input  logic               data_in_b,
  output logic               ttx_req,
  output logic               bit_data,
  output logic               bit_valid
);
  localparam int BC_W = $clog2(LINE_BITS + 1);
  localparam int GP_W = $clog2(GROUP_BITS + 1);
  localparam int CY_W = $clog2(LONG_HOLD);

  typedef struct packed {
    logic            act;
    logic [CY_W-1:0] cyc;
    logic [GP_W-1:0] gpos;
    logic [BC_W-1:0] bcnt;
  } tl_t;

  function automatic logic short_bit(input logic [GP_W-1:0] g);
    int gi;
    gi = int'(g);
    return (gi > 1) && (((gi - 1) % SHORT_STEP) == 0);
  endfunction

  function automatic logic last_slot(input tl_t s);
    logic [CY_W-1:0] lim;
    lim = short_bit(s.gpos) ? CY_W'(LONG_HOLD - 2) : CY_W'(LONG_HOLD - 1);
    return s.act && (s.cyc == lim);
  endfunction

  function automatic tl_t advance(input tl_t s);
    tl_t n;
    n = s;
    if (s.act) begin
      if (last_slot(s)) begin
        n.cyc  = '0;
        n.gpos = (s.gpos == GP_W'(GROUP_BITS)) ? GP_W'(1) : s.gpos + GP_W'(1);
        n.bcnt = s.bcnt + BC_W'(1);
        if (s.bcnt == BC_W'(LINE_BITS - 1)) n.act = 1'b0;
      end else begin
        n.cyc = s.cyc + CY_W'(1);
      end
    end
    return n;
  endfunction

  tl_t               main_q, lead_q;
  logic [WIDTH_W-1:0] pcnt;

  wire main_last = en && last_slot(main_q);
  wire lead_last = en && last_slot(lead_q);
  wire pick      = src_sel ? data_in_b : data_in_a;

  assign ttx_req = en && (req_bitmode ? (lead_last || (pcnt != '0)) : lead_q.act);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      main_q    <= '0;
      lead_q    <= '0;
      pcnt      <= '0;
      bit_data  <= 1'b0;
      bit_valid <= 1'b0;
    end else if (!en) begin
      main_q    <= '0;
      lead_q    <= '0;
      pcnt      <= '0;
      bit_valid <= 1'b0;
    end else if (line_start) begin
      main_q    <= '{act: 1'b1, cyc: '0, gpos: GP_W'(1), bcnt: '0};
      lead_q    <= '{act: 1'b1, cyc: CY_W'(req_lead), gpos: GP_W'(1), bcnt: '0};
      pcnt      <= '0;
      bit_valid <= 1'b0;
    end else begin
      main_q    <= advance(main_q);
      lead_q    <= advance(lead_q);
      pcnt      <= lead_last ? req_width : ((pcnt != '0) ? pcnt - WIDTH_W'(1) : '0);
      bit_valid <= main_last;
      if (main_last) bit_data <= pick;
    end
  end

  // R4: strobe lasts one cycle and slots are at least three clocks apart
  a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |=> !bit_valid);

  // R5: strobed bit matches the selected pin one clock earlier
  a_r5_source_pin: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |-> (bit_data == ($past(src_sel) ? $past(data_in_b) : $past(data_in_a))));

  // R1: disabling silences both outputs on the next cycle
  a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!bit_valid && !ttx_req));

  // R3: bit counter never runs past one line
  a_r3_line_bound: assert property (@(posedge clk) disable iff (!rst_n)
    main_q.bcnt <= BC_W'(LINE_BITS));

  // R3: finished timeline stays idle until restarted
  a_r3_idle_after_line: assert property (@(posedge clk) disable iff (!rst_n)
    (!main_q.act && !(en && line_start)) |=> !main_q.act);
endmodule

// File: tb/ttx_slot_timer_tb_top.sv
`timescale 1ns/1ps
module ttx_slot_timer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, req_bitmode = 1'b0, src_sel = 1'b0;
  logic [1:0] req_lead = 2'd0, req_width = 2'd0;
  logic line_start = 1'b0, data_in_a = 1'b0, data_in_b = 1'b0;
  logic ttx_req, bit_data, bit_valid;

  int total = 0, bad = 0, line_len = 0;
  bit done = 1'b0;
  int ends [0:359];
  bit endmap [0:1599];
  bit reqmap [0:1599];

  always #2 clk = ~clk;

  ttx_slot_timer dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .req_bitmode(req_bitmode), .src_sel(src_sel),
    .req_lead(req_lead), .req_width(req_width), .line_start(line_start),
    .data_in_a(data_in_a), .data_in_b(data_in_b),
    .ttx_req(ttx_req), .bit_data(bit_data), .bit_valid(bit_valid));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic pat_a(input int t);
    return (((t * 13) >> 3) ^ (t >> 1)) % 2 == 1;
  endfunction
  function automatic logic pat_b(input int t);
    return (((t * 5 + 3) >> 2) ^ (t >> 4)) % 2 == 1;
  endfunction

  task automatic build_sched();
    int t;
    t = 0;
    for (int i = 0; i < 1600; i++) endmap[i] = 1'b0;
    for (int k = 0; k < 360; k++) begin
      int p;
      p = (k % 37) + 1;
      t += ((p > 1) && ((p - 1) % 9 == 0)) ? 3 : 4;
      ends[k] = t - 1;
      endmap[t - 1] = 1'b1;
    end
    line_len = t;
  endtask

  task automatic run_line(input int ofs, input int wf, input bit bm, input bit sel);
    int nv;
    nv = 0;
    for (int i = 0; i < 1600; i++) reqmap[i] = 1'b0;
    if (!bm) begin
      for (int t = 0; t <= line_len - 1 - ofs; t++) reqmap[t] = 1'b1;
    end else begin
      for (int k = 0; k < 360; k++)
        for (int d = 0; d <= wf; d++) reqmap[ends[k] - ofs + d] = 1'b1;
    end
    req_lead = 2'(ofs); req_width = 2'(wf); req_bitmode = bm; src_sel = sel;
    line_start = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
    for (int t = 0; t < line_len + 8; t++) begin
      bit ev;
      ev = (t > 0) && endmap[t - 1];
      check(bit_valid == ev, "R2 R4 strobe timing", int'(bit_valid), int'(ev));
      if (ev) begin
        logic x;
        nv++;
        x = sel ? pat_b(t - 1) : pat_a(t - 1);
        check(bit_data == x, "R5 sampled data", int'(bit_data), int'(x));
      end
      check(ttx_req == reqmap[t], bm ? "R7 bit-mode request" : "R6 line-mode request",
            int'(ttx_req), int'(reqmap[t]));
      data_in_a = pat_a(t);
      data_in_b = pat_b(t);
      @(negedge clk);
    end
    check(nv == 360, "R3 strobes per line", nv, 360);
  endtask

  task automatic expect_quiet(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      check(!bit_valid && !ttx_req, req, int'(bit_valid) * 2 + int'(ttx_req), 0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    build_sched();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!bit_valid && !bit_data && !ttx_req, "R9 reset state",
          int'(bit_valid) * 4 + int'(bit_data) * 2 + int'(ttx_req), 0);

    // R8: start pulse while disabled is ignored, even once enabled later
    line_start = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
    expect_quiet(40, "R8 start ignored while off");
    en = 1'b1;
    expect_quiet(200, "R8 no line after late enable");

    // R6: line mode for each lead, alternating source pin
    for (int o = 0; o < 4; o++) run_line(o, o, 1'b0, o[0]);
    // R7: bit mode, every lead and width
    for (int o = 0; o < 4; o++)
      for (int w = 0; w < 4; w++) run_line(o, w, 1'b1, w[0] ^ o[1]);

    // R8: restart mid-line
    req_bitmode = 1'b0; req_lead = 2'd2; line_start = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
    repeat (501) @(negedge clk);
    run_line(1, 2, 1'b1, 1'b1);

    // R1: disable mid-line aborts the line
    req_bitmode = 1'b1; req_lead = 2'd0; req_width = 2'd1; line_start = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
    repeat (300) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    expect_quiet(100, "R1 quiet after disable");
    en = 1'b1;
    expect_quiet(200, "R1 no resume after enable");

    run_line(3, 3, 1'b0, 1'b0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule